// File: doc/BRIEF.md
# Addressed Serial Calibration Code Loader

This block is a low-rate configuration port that fills eight per-channel 6-bit calibration registers from a three-wire serial link. While the shift enable is high, each rising edge of the serial clock moves one data bit into a staging register. Bits arrive most significant first. The staged value stays put while the shift enable is low. A separate write strobe then copies the staged value into the channel register chosen by a 3-bit address. All eight stored codes are driven out in parallel, and the downstream trim converters read them from there.

All logic runs on the serial clock. The serial clock is slow, around 1 to 10 MHz, so timing is easy to meet. A guard watches the address during each load. A load window opens on the first edge that samples either the shift enable or the write strobe high. The guard records the address at that edge. The window stays open until one clock after the edge that samples the write strobe low again. If the address differs from the recorded value on any edge inside the window, the guard sets a sticky violation flag. A dedicated clear input resets the flag.

Top module: `cal_loader`

## Requirements
- R1: While the active-low asynchronous reset `rst_n` is low, the staging register, all eight channel codes and the violation flag are zero.
- R2: On each rising `sclk` edge with `shift_en` high, the staging register shifts left by one and takes `sdin` into bit 0. After six such edges, the first bit received sits in bit 5 and the last in bit 0.
- R3: When more than six shift edges occur, only the last six bits received are kept.
- R4: On edges with `shift_en` low, the staging register keeps its value whatever `sdin` does.
- R5: On a rising edge with `wr_en` high, the channel register selected by `addr` takes the staged value, and the other seven keep theirs. Channel k occupies bits [6k+5:6k] of `codes_o`.
- R6: On edges with `wr_en` low, no channel register changes.
- R7: When `shift_en` and `wr_en` are both high on one edge, the write stores the staged value from before that edge's shift.
- R8: On an edge with the guard idle, if `shift_en` or `wr_en` is high, a window opens and the guard records `addr`. The window stays open until the first edge that samples `wr_en` low after an edge that sampled it high. It then covers one more edge. If `addr` differs from the recorded value on any edge after the opening one while the window is open, `viol_o` is high after that edge.
- R9: `viol_o` stays high until an edge with `viol_clr` high clears it. If a mismatch occurs on that same edge, the flag stays set.
- R10: Address changes on edges outside a window never set `viol_o`. When the closing edge itself samples `shift_en` or `wr_en` high, it opens a new window with `addr` recorded at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock; all state updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sdin | input | 1 | Serial data bit |
| shift_en | input | 1 | Enables shifting `sdin` into the staging register |
| wr_en | input | 1 | Commits the staged code to the addressed channel |
| addr | input | 3 | Channel select for the write |
| viol_clr | input | 1 | Clears the sticky violation flag |
| codes_o | output | 48 | Eight 6-bit channel codes, channel k at [6k+5:6k] |
| viol_o | output | 1 | Sticky flag: address changed inside a load window |

## Verification
A corrupted staging register stays hidden until the next write. The bench therefore compares the whole code bus against a reference after every single clock, so the wrong value is caught on the edge that commits it. A guard that opens or closes its window one edge early or late shows up on `viol_o` within one clock of a targeted address change. Such changes are placed on the opening edge, inside the window, on the extra edge after the write and just past the window. A bit-order or write-timing fault appears as a wrong field on `codes_o` right after the first affected write.

// File: rtl/cal_loader_pkg.sv
package cal_loader_pkg;
    localparam int CAL_CODE_W = 6;
    localparam int CAL_NUM_CH = 8;

    typedef enum logic [1:0] {
        GRD_IDLE = 2'd0,
        GRD_OPEN = 2'd1,
        GRD_TAIL = 2'd2
    } grd_state_e;
endpackage

// File: rtl/cal_stage.sv
module cal_stage #(
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              sdin,
    output logic [CODE_W-1:0] stage_o
);
    typedef struct packed {
        logic [CODE_W-1:0] bits;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift_en) begin
            st_d.bits = {st_q.bits[CODE_W-2:0], sdin};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stage_o = st_q.bits;
endmodule

// File: rtl/cal_bank.sv
module cal_bank #(
    parameter int CODE_W = 6,
    parameter int NUM_CH = 8,
    parameter int ADDR_W = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [CODE_W-1:0]        wdata,
    output logic [NUM_CH*CODE_W-1:0] codes_o
);
    typedef struct packed {
        logic [NUM_CH-1:0][CODE_W-1:0] ch;
    } bank_t;

    bank_t bk_d, bk_q;
    logic [NUM_CH-1:0] sel;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_dec
        assign sel[g] = wr_en && (addr == ADDR_W'(g));
    end

    always_comb begin
        bk_d = bk_q;
        for (int i = 0; i < NUM_CH; i++) begin
            if (sel[i]) begin
                bk_d.ch[i] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bk_q <= '0;
        end else begin
            bk_q <= bk_d;
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_out
        assign codes_o[g*CODE_W +: CODE_W] = bk_q.ch[g];
    end
endmodule

// File: rtl/cal_addr_guard.sv
module cal_addr_guard
    import cal_loader_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              viol_clr,
    output logic              viol_o
);
    typedef struct packed {
        grd_state_e        state;
        logic [ADDR_W-1:0] ref_addr;
        logic              wr_prev;
        logic              viol;
    } guard_t;

    guard_t gd_d, gd_q;
    logic   mismatch;
    logic   start;

    assign mismatch = (gd_q.state != GRD_IDLE) && (addr != gd_q.ref_addr);
    assign start    = shift_en || wr_en;

    always_comb begin
        gd_d         = gd_q;
        gd_d.wr_prev = wr_en;
        gd_d.viol    = mismatch || (gd_q.viol && !viol_clr);
        unique case (gd_q.state)
            GRD_IDLE: begin
                if (start) begin
                    gd_d.state    = GRD_OPEN;
                    gd_d.ref_addr = addr;
                end
            end
            GRD_OPEN: begin
                if (!wr_en && gd_q.wr_prev) begin
                    gd_d.state = GRD_TAIL;
                end
            end
            GRD_TAIL: begin
                if (start) begin
                    gd_d.state    = GRD_OPEN;
                    gd_d.ref_addr = addr;
                end else begin
                    gd_d.state = GRD_IDLE;
                end
            end
            default: gd_d.state = GRD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gd_q <= '{state: GRD_IDLE, ref_addr: '0, wr_prev: 1'b0, viol: 1'b0};
        end else begin
            gd_q <= gd_d;
        end
    end

    assign viol_o = gd_q.viol;
endmodule

// File: rtl/cal_loader.sv
module cal_loader
    import cal_loader_pkg::*;
#(
    parameter int CODE_W = CAL_CODE_W,
    parameter int NUM_CH = CAL_NUM_CH,
    localparam int ADDR_W = $clog2(NUM_CH)
) (
    input  logic                     sclk,
    input  logic                     rst_n,
    input  logic                     sdin,
    input  logic                     shift_en,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        addr,
    input  logic                     viol_clr,
    output logic [NUM_CH*CODE_W-1:0] codes_o,
    output logic                     viol_o
);
    logic [CODE_W-1:0] stage_w;

    cal_stage #(.CODE_W(CODE_W)) u_stage (
        .clk      (sclk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .sdin     (sdin),
        .stage_o  (stage_w)
    );

    cal_bank #(.CODE_W(CODE_W), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_bank (
        .clk     (sclk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (stage_w),
        .codes_o (codes_o)
    );

    cal_addr_guard #(.ADDR_W(ADDR_W)) u_guard (
        .clk      (sclk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .wr_en    (wr_en),
        .addr     (addr),
        .viol_clr (viol_clr),
        .viol_o   (viol_o)
    );
endmodule

// File: rtl/cal_loader_chk.sv
module cal_loader_chk #(
    parameter int CODE_W = 6,
    parameter int NUM_CH = 8,
    parameter int ADDR_W = 3
) (
    input logic                     sclk,
    input logic                     rst_n,
    input logic                     shift_en,
    input logic                     wr_en,
    input logic [ADDR_W-1:0]        addr,
    input logic                     viol_clr,
    input logic [CODE_W-1:0]        stage_w,
    input logic [NUM_CH*CODE_W-1:0] codes_o,
    input logic                     viol_o
);
    logic [ADDR_W-1:0] addr_p;
    logic [CODE_W-1:0] stage_p;
    logic              wr_p;

    always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n) begin
            addr_p  <= '0;
            stage_p <= '0;
            wr_p    <= 1'b0;
        end else begin
            addr_p  <= addr;
            stage_p <= stage_w;
            wr_p    <= wr_en;
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge sclk) !rst_n |-> (codes_o == '0 && !viol_o && stage_w == '0));

    // R4
    stage_hold_chk: assert property (@(posedge sclk) disable iff (!rst_n) !shift_en |=> $stable(stage_w));

    // R5
    write_lands_chk: assert property (@(posedge sclk) disable iff (!rst_n)
        wr_p |-> codes_o[addr_p*CODE_W +: CODE_W] == stage_p);

    // R6
    no_write_chk: assert property (@(posedge sclk) disable iff (!rst_n) !wr_en |=> $stable(codes_o));

    // R9
    viol_sticky_chk: assert property (@(posedge sclk) disable iff (!rst_n) (viol_o && !viol_clr) |=> viol_o);

    // R9
    viol_fall_chk: assert property (@(posedge sclk) disable iff (!rst_n) $fell(viol_o) |-> $past(viol_clr));
endmodule

bind cal_loader cal_loader_chk #(.CODE_W(CODE_W), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
    .sclk     (sclk),
    .rst_n    (rst_n),
    .shift_en (shift_en),
    .wr_en    (wr_en),
    .addr     (addr),
    .viol_clr (viol_clr),
    .stage_w  (stage_w),
    .codes_o  (codes_o),
    .viol_o   (viol_o)
);

// File: tb/sim_cal_loader.sv
module sim_cal_loader;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sdin = 1'b0;
    logic        shift_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic        viol_clr = 1'b0;
    logic [47:0] codes_o;
    logic        viol_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // reference model state
    logic [5:0] m_stage;
    logic [5:0] m_bank [8];
    logic       m_viol;
    int         m_state;   // 0 idle, 1 open, 2 tail
    logic [2:0] m_ref;
    logic       m_wrp;

    always #5 clk = ~clk;

    cal_loader u0 (
        .sclk(clk), .rst_n(rst_n), .sdin(sdin), .shift_en(shift_en), .wr_en(wr_en),
        .addr(addr), .viol_clr(viol_clr), .codes_o(codes_o), .viol_o(viol_o)
    );

    task automatic model_reset();
        m_stage = '0;
        for (int i = 0; i < 8; i++) m_bank[i] = '0;
        m_viol = 1'b0; m_state = 0; m_ref = '0; m_wrp = 1'b0;
    endtask

    function automatic logic [5:0] code_of(input logic [47:0] bus, input int ch);
        return bus[ch*6 +: 6];
    endfunction

    // one rising edge: model advances on the sampled inputs, then move to the falling edge
    task automatic tick();
        logic mis;
        logic [5:0] old_stage;
        @(posedge clk);
        if (rst_n) begin
            mis = (m_state != 0) && (addr != m_ref);
            old_stage = m_stage;
            if (wr_en) m_bank[addr] = old_stage;
            if (shift_en) m_stage = {m_stage[4:0], sdin};
            case (m_state)
                0: if (shift_en || wr_en) begin m_state = 1; m_ref = addr; end
                1: if (!wr_en && m_wrp) m_state = 2;
                default: if (shift_en || wr_en) begin m_state = 1; m_ref = addr; end
                         else m_state = 0;
            endcase
            m_wrp  = wr_en;
            m_viol = mis || (m_viol && !viol_clr);
        end
        @(negedge clk);
    endtask

    task automatic chk_code(input int ch, input logic [5:0] exp, input string req);
        checks++;
        if (code_of(codes_o, ch) !== exp) begin
            failures++;
            $display("FAIL %s ch%0d code actual=%b expected=%b", req, ch, code_of(codes_o, ch), exp);
        end
    endtask

    task automatic chk_viol(input logic exp, input string req);
        checks++;
        if (viol_o !== exp) begin
            failures++;
            $display("FAIL %s viol actual=%b expected=%b", req, viol_o, exp);
        end
    endtask

    task automatic chk_all(input string req);
        for (int i = 0; i < 8; i++) chk_code(i, m_bank[i], req);
        chk_viol(m_viol, req);
    endtask

    task automatic shift_bits(input logic [15:0] bits, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            shift_en = 1'b1; sdin = bits[i];
            tick();
        end
        shift_en = 1'b0; sdin = 1'b0;
    endtask

    task automatic write_once();
        wr_en = 1'b1; tick();
        wr_en = 1'b0; tick();   // edge sampling write low
        tick();                 // extra protected edge
    endtask

    initial begin
        #200000;
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_c0de));
        model_reset();
        repeat (3) @(negedge clk);
        // R1: state during reset
        for (int i = 0; i < 8; i++) chk_code(i, 6'd0, "R1");
        chk_viol(1'b0, "R1");
        rst_n = 1'b1;
        @(negedge clk);

        // R2: MSB-first order into channel 3
        addr = 3'd3;
        shift_bits(16'b101100, 6);
        write_once();
        chk_code(3, 6'b101100, "R2");
        chk_all("R5");

        // R3: nine bits, last six kept, channel 5
        addr = 3'd5;
        shift_bits(16'b111_010011, 9);
        write_once();
        chk_code(5, 6'b010011, "R3");

        // R4: idle gap with sdin toggling before the write, channel 0
        addr = 3'd0;
        shift_bits(16'b110001, 6);
        for (int i = 0; i < 4; i++) begin sdin = i[0]; tick(); end
        write_once();
        chk_code(0, 6'b110001, "R4");

        // R6: address sweeps with write low do not change any code
        for (int i = 0; i < 8; i++) begin addr = 3'(i); sdin = 1'b1; tick(); end
        chk_all("R6");
        chk_code(3, 6'b101100, "R6");

        // R7: write and shift on the same edge store the older stage
        addr = 3'd6;
        shift_en = 1'b1; wr_en = 1'b1; sdin = 1'b0;
        tick();
        shift_en = 1'b0; wr_en = 1'b0;
        tick(); tick();
        chk_code(6, 6'b110001, "R7");
        chk_viol(1'b0, "R10");

        // R8: address change in the middle of a shift
        addr = 3'd1;
        shift_en = 1'b1; sdin = 1'b1; tick();
        addr = 3'd2; tick();
        shift_en = 1'b0; addr = 3'd1;
        chk_viol(1'b1, "R8");
        write_once();
        // R9: flag stays until cleared
        tick(); tick();
        chk_viol(1'b1, "R9");
        viol_clr = 1'b1; tick(); viol_clr = 1'b0;
        chk_viol(1'b0, "R9");

        // R8: change on the extra edge after write deassert
        addr = 3'd4;
        shift_bits(16'b000111, 6);
        wr_en = 1'b1; tick();
        wr_en = 1'b0; tick();
        addr = 3'd7; tick();
        chk_viol(1'b1, "R8");
        chk_code(4, 6'b000111, "R5");
        viol_clr = 1'b1; tick(); viol_clr = 1'b0;

        // R10: change one edge after the protected window
        addr = 3'd2;
        shift_bits(16'b011011, 6);
        write_once();
        addr = 3'd5; tick();
        chk_viol(1'b0, "R10");

        // R9: clear on the same edge as a mismatch keeps the flag
        addr = 3'd0;
        shift_en = 1'b1; tick();
        addr = 3'd1; viol_clr = 1'b1; tick();
        viol_clr = 1'b0; shift_en = 1'b0; addr = 3'd0;
        chk_viol(1'b1, "R9");
        write_once();
        viol_clr = 1'b1; tick(); viol_clr = 1'b0;
        chk_all("R9");

        // constrained random traffic, compared every edge
        for (int n = 0; n < 3000; n++) begin
            int r;
            r = int'($urandom_range(0, 99));
            shift_en = (r < 45);
            wr_en    = ($urandom_range(0, 99) < 15);
            sdin     = 1'($urandom);
            viol_clr = ($urandom_range(0, 99) < 5);
            if ($urandom_range(0, 99) < 8) addr = 3'($urandom);
            tick();
            chk_all("R5");
        end
        shift_en = 1'b0; wr_en = 1'b0; viol_clr = 1'b0;

        // R1: reset mid-run clears everything
        rst_n = 1'b0;
        #1;
        model_reset();
        for (int i = 0; i < 8; i++) chk_code(i, 6'd0, "R1");
        chk_viol(1'b0, "R1");
        @(negedge clk);
        rst_n = 1'b1;
        tick();
        chk_all("R1");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule